// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that walks a linked list of transfer descriptors kept in memory. Software loads the address of the first descriptor into the descriptor-pointer register and sets the run bit in the control register. The channel then reads the eight-word descriptor itself and copies data one 32-bit word per beat from the source address to the destination address. It then follows the descriptor's link field to the next descriptor and stops when that link is zero.

Each descriptor carries a flag word. The flags choose whether the source and destination addresses step forward, whether source reads are skipped and zeros written instead, whether reads or writes wait on a selected peripheral request line, and whether finishing the descriptor raises the interrupt. The control register can pause the channel, abandon the current descriptor, or clear the whole channel. The registers above it show the live descriptor fields, so software can see where a transfer stands.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the descriptor pointer and all six field views read zero, `irq` and `mem_req` are low, and the control register reads 0x10: only the not-running bit 4 is set.
- R2: Register word indices are 0 control, 1 descriptor pointer, 2 flags, 3 source, 4 destination, 5 byte count, 6 stride, 7 link. A descriptor is eight words at the pointer in that field order, with two unused words at the end. The low five bits of a written pointer or a fetched link are forced to zero. Once fetched, the field views show the descriptor's values.
- R3: Each beat reads one word at the source address and writes it at the destination address. An address advances by 4 after each beat only when its step flag is set: flag bit 8 for the source, bit 4 for the destination. Otherwise the address stays fixed.
- R4: With flag bit 11 set, no source reads are issued and each beat writes zero.
- R5: Flag bits 20:16 select one request line. With bit 10 set, reads wait while that line is low. With bit 6 set, writes wait the same way. Control bit 3 reads the selected line.
- R6: After a descriptor, the channel fetches the descriptor at its link. A zero link stops the chain: the pointer then reads zero and control bit 0 clears.
- R7: When a descriptor finishes, control bit 1 sets. If flag bit 0 is set, control bit 2 and `irq` also set. Writing 1 to bit 1 or bit 2 clears that bit.
- R8: Writing 0 to control bit 0 stops new memory requests and keeps the current position. Writing 1 continues the transfer to completion.
- R9: Writing control bit 30 while a descriptor runs abandons it at the next beat boundary. The channel moves on to the link without setting bit 1 or bit 2.
- R10: Writing control bit 31 returns the channel to its reset state at once.
- R11: A pointer write is accepted only while the channel is idle, or paused with no access in flight. At any other time it is ignored.
- R12: The byte count is rounded down to a multiple of 4 and limited to 65532 when LITE=1, or to 1 GiB otherwise. A count of zero finishes the descriptor with no data beats.
- R13: Once `mem_req` is raised, it and `mem_addr` and `mem_we` hold steady until the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the pending access |
| dreq_lines | input | REQ_LINES | Peripheral request lines |
| irq | output | 1 | Interrupt, equal to control bit 2 |

## Verification
The assertions assume the memory acknowledges only a pending request, with one single-cycle `mem_ack` per request and no acknowledge while `mem_req` is low. They also assume only one register write per cycle. The bench memory model raises `mem_ack` only after it sees `mem_req`, drops it the next cycle, and adds a latency of 0 to 2 cycles. Request lines change only at the falling edge, so pacing decisions never race the sampling edge.

// File: rtl/dce_pkg.sv
package dce_pkg;
    localparam int CB_WORDS   = 8;
    localparam int IDX_W      = $clog2(CB_WORDS);
    localparam int ALIGN_BITS = $clog2(CB_WORDS * 4);
    localparam int WORD_BYTES = 4;
    localparam int SEL_W      = 5;

    localparam int CS_RUN    = 0;
    localparam int CS_DONE   = 1;
    localparam int CS_INT    = 2;
    localparam int CS_LINE   = 3;
    localparam int CS_HALT   = 4;
    localparam int CS_WWAIT  = 6;
    localparam int CS_SKIP   = 30;
    localparam int CS_CLEAR  = 31;

    localparam int FL_IRQ    = 0;
    localparam int FL_DSTEP  = 4;
    localparam int FL_DPACE  = 6;
    localparam int FL_SSTEP  = 8;
    localparam int FL_SPACE  = 10;
    localparam int FL_ZERO   = 11;
    localparam int FL_SEL_LO = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_NEXT
    } dce_state_e;

    typedef struct packed {
        dce_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             req;
        logic             run;
        logic             done_f;
        logic             irq_f;
        logic             skip;
        logic [31:0]      cb;
        logic [31:0]      flags;
        logic [31:0]      src;
        logic [31:0]      dst;
        logic [31:0]      len;
        logic [31:0]      stride;
        logic [31:0]      link;
        logic [31:0]      data;
    } dce_regs_t;
endpackage

// File: rtl/dce_line_pick.sv
module dce_line_pick #(
    parameter int LINES = 32,
    parameter int SEL_W = 5
) (
    input  logic [LINES-1:0] lines,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign match[g] = (sel == SEL_W'(g)) && lines[g];
    end

    assign hit = |match;
endmodule

// File: rtl/dce_len_fit.sv
module dce_len_fit #(
    parameter logic [31:0] MAX_LEN = 32'h4000_0000
) (
    input  logic [31:0] raw,
    output logic [31:0] fit
);
    logic [31:0] whole;

    assign whole = {raw[31:2], 2'b00};
    assign fit   = (whole > MAX_LEN) ? MAX_LEN : whole;
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dce_pkg::*;
#(
    parameter int REQ_LINES = 32,
    parameter bit LITE      = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    input  logic                 mem_ack,
    input  logic [REQ_LINES-1:0] dreq_lines,
    output logic                 irq
);
    localparam logic [31:0] MAX_LEN = LITE ? 32'd65532 : 32'h4000_0000;
    localparam logic [31:0] STEP    = 32'(WORD_BYTES);

    dce_regs_t   q, d;
    logic        line_hit;
    logic [31:0] len_fit;
    logic        cs_wr, cb_wr;
    logic [31:0] cs_view;
    logic        run_now;

    dce_line_pick #(.LINES(REQ_LINES), .SEL_W(SEL_W)) u_pick (
        .lines (dreq_lines),
        .sel   (q.flags[FL_SEL_LO +: SEL_W]),
        .hit   (line_hit)
    );

    dce_len_fit #(.MAX_LEN(MAX_LEN)) u_fit (
        .raw (mem_rdata),
        .fit (len_fit)
    );

    assign cs_wr = reg_we && (reg_sel == 3'd0);
    assign cb_wr = reg_we && (reg_sel == 3'd1);

    always_comb begin
        d = q;
        // software control writes first; engine events below override them
        if (cs_wr) begin
            d.run = reg_wdata[CS_RUN];
            if (reg_wdata[CS_DONE]) d.done_f = 1'b0;
            if (reg_wdata[CS_INT])  d.irq_f  = 1'b0;
            if (reg_wdata[CS_SKIP] && q.st != ST_IDLE) d.skip = 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                d.skip = 1'b0;
                if (q.run && q.cb != '0) begin
                    d.st  = ST_FETCH;
                    d.idx = '0;
                end
            end
            ST_FETCH: begin
                if (q.req) begin
                    if (mem_ack) begin
                        d.req = 1'b0;
                        case (q.idx)
                            3'd0: d.flags  = mem_rdata;
                            3'd1: d.src    = mem_rdata;
                            3'd2: d.dst    = mem_rdata;
                            3'd3: d.len    = len_fit;
                            3'd4: d.stride = mem_rdata;
                            3'd5: d.link   = {mem_rdata[31:ALIGN_BITS], ALIGN_BITS'(0)};
                            default: ;
                        endcase
                        if (q.idx == IDX_W'(CB_WORDS - 1)) begin
                            if (q.len == '0) begin
                                d.st     = ST_NEXT;
                                d.done_f = 1'b1;
                                if (q.flags[FL_IRQ]) d.irq_f = 1'b1;
                            end else begin
                                d.st = ST_READ;
                            end
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end else if (q.run) begin
                    d.req = 1'b1;
                end
            end
            ST_READ: begin
                if (q.req) begin
                    if (mem_ack) begin
                        d.req  = 1'b0;
                        d.data = mem_rdata;
                        d.st   = ST_WRITE;
                    end
                end else if (q.skip) begin
                    d.skip = 1'b0;
                    d.st   = ST_NEXT;
                end else if (q.run && (!q.flags[FL_SPACE] || line_hit)) begin
                    if (q.flags[FL_ZERO]) begin
                        d.data = '0;
                        d.st   = ST_WRITE;
                    end else begin
                        d.req = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (q.req) begin
                    if (mem_ack) begin
                        d.req = 1'b0;
                        if (q.flags[FL_SSTEP]) d.src = q.src + STEP;
                        if (q.flags[FL_DSTEP]) d.dst = q.dst + STEP;
                        d.len = q.len - STEP;
                        if (q.len <= STEP) begin
                            d.st     = ST_NEXT;
                            d.done_f = 1'b1;
                            if (q.flags[FL_IRQ]) d.irq_f = 1'b1;
                        end else begin
                            d.st = ST_READ;
                        end
                    end
                end else if (q.skip) begin
                    d.skip = 1'b0;
                    d.st   = ST_NEXT;
                end else if (q.run && (!q.flags[FL_DPACE] || line_hit)) begin
                    d.req = 1'b1;
                end
            end
            ST_NEXT: begin
                d.cb   = q.link;
                d.idx  = '0;
                d.skip = 1'b0;
                if (q.link == '0) begin
                    d.st  = ST_IDLE;
                    d.run = 1'b0;
                end else begin
                    d.st = ST_FETCH;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (cb_wr && (q.st == ST_IDLE || (!q.run && !q.req))) begin
            d.cb   = {reg_wdata[31:ALIGN_BITS], ALIGN_BITS'(0)};
            d.st   = ST_IDLE;
            d.idx  = '0;
            d.skip = 1'b0;
        end
        if (cs_wr && reg_wdata[CS_CLEAR]) d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        cs_view            = '0;
        cs_view[CS_RUN]    = q.run;
        cs_view[CS_DONE]   = q.done_f;
        cs_view[CS_INT]    = q.irq_f;
        cs_view[CS_LINE]   = line_hit;
        cs_view[CS_HALT]   = !(q.run && q.st != ST_IDLE);
        cs_view[CS_WWAIT]  = q.req && q.st == ST_WRITE;
        case (reg_sel)
            3'd0:    reg_rdata = cs_view;
            3'd1:    reg_rdata = q.cb;
            3'd2:    reg_rdata = q.flags;
            3'd3:    reg_rdata = q.src;
            3'd4:    reg_rdata = q.dst;
            3'd5:    reg_rdata = q.len;
            3'd6:    reg_rdata = q.stride;
            default: reg_rdata = q.link;
        endcase
        case (q.st)
            ST_FETCH: mem_addr = q.cb + {27'd0, q.idx, 2'b00};
            ST_READ:  mem_addr = q.src;
            ST_WRITE: mem_addr = q.dst;
            default:  mem_addr = '0;
        endcase
    end

    assign mem_req   = q.req;
    assign mem_we    = (q.st == ST_WRITE);
    assign mem_wdata = q.data;
    assign irq       = q.irq_f;
    assign run_now   = q.run;
endmodule

// File: rtl/dce_checker.sv
module dce_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        irq,
    input logic        run_q
);
    logic cs_write, clear_write;

    assign cs_write    = reg_we && reg_sel == 3'd0;
    assign clear_write = cs_write && reg_wdata[31];

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !clear_write) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_irq_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_ack));

    assert_pause_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !mem_req && !cs_write) |=> !mem_req);

    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_write |=> (!mem_req && !irq && !run_q));
endmodule

bind dma_chain_engine dce_checker u_dce_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .irq       (irq),
    .run_q     (run_now)
);

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] dreq_lines = '0;
    logic        irq;

    logic [31:0] mem [0:255];
    int          lat = 0;
    int          wait_cnt = 0;
    int          src_reads = 0;
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    logic        hold_bad = 1'b0;
    logic [1:0]  dreq_mode = 2'd1;
    logic [31:0] dreq_manual = '0;
    logic [3:0]  phase = '0;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    dma_chain_engine #(.REQ_LINES(32), .LITE(1'b1)) i_dma_chain_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dreq_lines(dreq_lines), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_cnt <= 0;
            held <= 1'b0;
        end else begin
            held <= mem_req && !mem_ack;
            held_addr <= mem_addr;
            if (held && mem_req && mem_addr != held_addr) hold_bad <= 1'b1;
            if (mem_ack) mem_ack <= 1'b0;
            else if (mem_req) begin
                if (wait_cnt < lat) wait_cnt <= wait_cnt + 1;
                else begin
                    wait_cnt <= 0;
                    mem_ack <= 1'b1;
                    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                    else begin
                        mem_rdata <= mem[mem_addr[9:2]];
                        if (mem_addr[9:8] == 2'b10) src_reads <= src_reads + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        phase <= phase + 1'b1;
        dreq_lines <= (dreq_mode == 2'd2) ? {32{phase[1]}} : dreq_manual;
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic put_cb(input int byte_addr, input logic [31:0] fl, input logic [31:0] s,
                          input logic [31:0] dd, input logic [31:0] n, input logic [31:0] st,
                          input logic [31:0] lk);
        int b = byte_addr / 4;
        mem[b] = fl; mem[b+1] = s; mem[b+2] = dd; mem[b+3] = n;
        mem[b+4] = st; mem[b+5] = lk; mem[b+6] = 32'hFFFF_FFFF; mem[b+7] = 32'hFFFF_FFFF;
    endtask

    task automatic start_at(input logic [31:0] cb);
        reg_write(3'd1, cb);
        reg_write(3'd0, 32'h1);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            reg_read(3'd1, v);
            if (v == '0) return;
        end
        check_eq({tag, " chain never ended"}, v, 32'h0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v, s1, s2, fl, exp_w;
        logic [31:0] exp_dst [0:7];
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(3'd0, v); check_eq("R1 control", v, 32'h10);
        for (int r = 1; r < 8; r++) begin
            reg_read(3'(r), v); check_eq("R1 field view", v, 32'h0);
        end
        check_eq("R1 irq", {31'd0, irq}, 32'd0);
        check_eq("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // R3 R4 R5 R7 R12: sweep of step/zero/pace flags, lengths and latency
        for (int c = 0; c < 32; c++) begin
            int si = c & 1, di = (c >> 1) & 1, zf = (c >> 2) & 1;
            int sz = (c >> 3) & 3;
            int nw = (sz == 0) ? 0 : (sz == 1) ? 1 : (sz == 2) ? 3 : 5;
            int pace = (c >> 3) & 1;
            int ie = ((c >> 1) ^ (c >> 2)) & 1;
            lat = c % 3;
            for (int i = 0; i < 8; i++) begin
                mem[8'h80 + i] = 32'h1000_0000 + c * 256 + i;
                mem[8'hC0 + i] = 32'hDEAD_BEEF;
                exp_dst[i] = 32'hDEAD_BEEF;
            end
            for (int b = 0; b < nw; b++) begin
                exp_w = zf ? 32'h0 : mem[8'h80 + (si ? b : 0)];
                exp_dst[di ? b : 0] = exp_w;
            end
            fl = (32'(si) << 8) | (32'(di) << 4) | (32'(zf) << 11) | 32'(ie);
            if (pace != 0) fl = fl | (32'h1 << 10) | (32'h1 << 6) | (32'd3 << 16);
            dreq_mode = pace ? 2'd2 : 2'd1;
            dreq_manual = '1;
            put_cb(32'h100, fl, 32'h200, 32'h300, 32'(nw * 4 + (zf ? 2 : 0)), 32'h0, 32'h0);
            src_reads = 0;
            start_at(32'h100);
            wait_idle("R6 sweep");
            for (int i = 0; i < 8; i++) check_eq("R3 dest word", mem[8'hC0 + i], exp_dst[i]);
            check_eq("R4 source reads", 32'(src_reads), zf ? 32'h0 : 32'(nw));
            reg_read(3'd3, v); check_eq("R3 source end", v, 32'h200 + (si ? 32'(nw * 4) : 0));
            reg_read(3'd4, v); check_eq("R3 dest end", v, 32'h300 + (di ? 32'(nw * 4) : 0));
            reg_read(3'd5, v); check_eq("R12 count drained", v, 32'h0);
            reg_read(3'd0, v); check_eq("R7 done flag", {31'd0, v[1]}, 32'd1);
            check_eq("R7 irq level", {31'd0, irq}, 32'(ie));
            reg_write(3'd0, 32'h6);
            reg_read(3'd0, v); check_eq("R7 flags cleared", {30'd0, v[2:1]}, 32'd0);
            check_eq("R7 irq cleared", {31'd0, irq}, 32'd0);
        end

        // R6: two-descriptor chain
        lat = 1; dreq_mode = 2'd1;
        for (int i = 0; i < 8; i++) begin
            mem[8'h80 + i] = 32'hC000_0000 + i;
            mem[8'hC0 + i] = 32'hDEAD_BEEF;
        end
        put_cb(32'h100, 32'h110, 32'h200, 32'h300, 32'd8, 32'h0, 32'h14F);
        put_cb(32'h140, 32'h111, 32'h210, 32'h310, 32'd12, 32'h0, 32'h0);
        start_at(32'h100);
        wait_idle("R6 chain");
        check_eq("R6 first block", mem[8'hC1], 32'hC000_0001);
        check_eq("R6 second block", mem[8'hC6], 32'hC000_0006);
        check_eq("R6 gap untouched", mem[8'hC2], 32'hDEAD_BEEF);
        reg_read(3'd0, v); check_eq("R6 run cleared", {31'd0, v[0]}, 32'd0);
        check_eq("R6 irq from last", {31'd0, irq}, 32'd1);
        reg_write(3'd0, 32'h6);

        // R2 R5 R11 R12 R10: paced stall, field views, pointer lock, soft clear
        lat = 0; dreq_manual = '0;
        put_cb(32'h180, 32'h0005_0510, 32'h200, 32'h300, 32'hFFFF_FFFF, 32'h55, 32'h0);
        reg_write(3'd1, 32'h18F);
        reg_read(3'd1, v); check_eq("R2 pointer aligned R11 idle accept", v, 32'h180);
        reg_write(3'd0, 32'h1);
        repeat (60) @(negedge clk);
        reg_read(3'd2, v); check_eq("R2 flags view", v, 32'h0005_0510);
        reg_read(3'd4, v); check_eq("R2 dest view", v, 32'h300);
        reg_read(3'd5, v); check_eq("R12 lite limit", v, 32'd65532);
        reg_read(3'd6, v); check_eq("R2 stride view", v, 32'h55);
        reg_read(3'd7, v); check_eq("R2 link view", v, 32'h0);
        reg_read(3'd0, v); check_eq("R5 line low", {31'd0, v[3]}, 32'd0);
        reg_write(3'd1, 32'h1C0);
        reg_read(3'd1, v); check_eq("R11 busy write ignored", v, 32'h180);
        dreq_manual = 32'h10;
        repeat (6) @(negedge clk);
        reg_read(3'd0, v); check_eq("R5 other line ignored", {31'd0, v[3]}, 32'd0);
        reg_read(3'd3, v); check_eq("R5 stalled source", v, 32'h200);
        dreq_manual = 32'h20;
        repeat (4) @(negedge clk);
        reg_read(3'd0, v); check_eq("R5 line high", {31'd0, v[3]}, 32'd1);
        repeat (20) @(negedge clk);
        reg_read(3'd3, v); check_eq("R5 resumed", {31'd0, v != 32'h200}, 32'd1);
        reg_write(3'd0, 32'h8000_0000);
        reg_read(3'd0, v); check_eq("R10 control", v, 32'h10);
        for (int r = 1; r < 8; r++) begin
            reg_read(3'(r), v); check_eq("R10 field view", v, 32'h0);
        end
        check_eq("R10 irq", {31'd0, irq}, 32'd0);
        dreq_manual = '1;
        repeat (10) @(negedge clk);

        // R8: pause keeps position, resume completes
        lat = 2;
        for (int i = 0; i < 8; i++) begin
            mem[8'h80 + i] = 32'h5A00_0000 + i;
            mem[8'hC0 + i] = 32'hDEAD_BEEF;
        end
        put_cb(32'h100, 32'h110, 32'h200, 32'h300, 32'd24, 32'h0, 32'h0);
        start_at(32'h100);
        repeat (8) @(negedge clk);
        reg_write(3'd0, 32'h0);
        repeat (10) @(negedge clk);
        reg_read(3'd3, s1);
        repeat (20) @(negedge clk);
        reg_read(3'd3, s2);
        check_eq("R8 position held", s2, s1);
        reg_read(3'd1, v); check_eq("R8 pointer kept", {31'd0, v != 0}, 32'd1);
        reg_read(3'd0, v); check_eq("R8 halt bit", {31'd0, v[4]}, 32'd1);
        reg_write(3'd0, 32'h1);
        wait_idle("R8 resume");
        check_eq("R8 first word", mem[8'hC0], 32'h5A00_0000);
        check_eq("R8 last word", mem[8'hC5], 32'h5A00_0005);
        reg_write(3'd0, 32'h6);

        // R9: abandon first descriptor, second still runs
        for (int i = 0; i < 8; i++) begin
            mem[8'h80 + i] = 32'h7700_0000 + i;
            mem[8'hC0 + i] = 32'hDEAD_BEEF;
            mem[8'hD0 + i] = 32'hDEAD_BEEF;
        end
        mem[8'h88] = 32'h7711_0000; mem[8'h89] = 32'h7711_0001;
        put_cb(32'h100, 32'h111, 32'h200, 32'h300, 32'd32, 32'h0, 32'h140);
        put_cb(32'h140, 32'h110, 32'h220, 32'h340, 32'd8, 32'h0, 32'h0);
        start_at(32'h100);
        repeat (10) @(negedge clk);
        reg_write(3'd0, 32'h4000_0001);
        wait_idle("R9 chain");
        check_eq("R9 first tail skipped", mem[8'hC7], 32'hDEAD_BEEF);
        check_eq("R9 second copied", mem[8'hD1], 32'h7711_0001);
        check_eq("R9 no irq", {31'd0, irq}, 32'd0);

        check_eq("R13 request held", {31'd0, hold_bad}, 32'd0);
        summary();
    end
endmodule